// File: doc/BRIEF.md
# Sixteen-Pin GPIO Controller with Pin Interrupts

This block gives software control of a bank of sixteen general-purpose pins through a small set of 16-bit registers, with one bit per pin. Each pin can be made an input or an output. Output levels change through dedicated write-one-to-set and write-one-to-clear ports, so two agents can update different pins without a read-modify-write race. The whole output latch can also be loaded or read back. Pin inputs pass through a two-flop synchroniser, and the synchronised value can be read.

Every pin can request an interrupt. A pin can be level-sensitive, active high or active low. It can also be edge-sensitive on the rising edge, the falling edge or both. An edge sets a sticky pending bit that software removes by writing a one to the clear register. A level source reports pending for as long as the level holds. A pending pin reaches the status register only when its mask bit is 0 and its enable bit is 1. All gated status bits are ORed into one registered interrupt line.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset the mask register (0x28) reads 0xFFFF. The direction (0x00), mode-select (0x04), polarity (0x08), rise-enable (0x0C), fall-enable (0x10), output (0x20), enable (0x2C) and status (0x30) registers read 0. The irq output and pin_oe are 0.
- R2: pin_oe equals the direction register. A direction bit of 1 makes the pin an output.
- R3: Writing 0x18 sets the output bits written as 1, and writing 0x1C clears them. Bits written as 0 keep their value. Writing 0x20 loads the whole latch. pin_out and a read of 0x20 show the latch.
- R4: A read of 0x14 returns pin_in two clock edges after the pins change, and still the old value after one edge.
- R5: An edge-mode pin (mode-select bit 0) becomes pending on a rising edge when its rise-enable bit (0x0C) is 1. It becomes pending on a falling edge when its fall-enable bit (0x10) is 1. With both bits set it becomes pending on either edge. The pending bit stays set until cleared.
- R6: A level-mode pin (mode-select bit 1) is pending while its synchronised input equals its polarity bit (1 means active high). Clearing it has no effect while that level holds.
- R7: Status (0x30) reads pending & ~mask & enable.
- R8: Writing 0x34 removes the edge-pending bits written as 1 and leaves the others.
- R9: irq equals the OR of the status bits, delayed by one clock.
- R10: Reads of addresses that hold no register return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Byte address of the register |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr (combinational) |
| pin_in | input | 16 | Pin input levels |
| pin_out | output | 16 | Output latch |
| pin_oe | output | 16 | Output enable per pin |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions take for granted that a write arrives as a single-cycle strobe with a stable address and data, and that pin_in is asynchronous. They check behaviour only after synchronisation, so no property depends on when a pin changes relative to the clock. The stimulus moves pins and register accesses only on the falling clock edge and holds every pin level for several cycles. This keeps each edge distinct and lets the bench predict pending bits from the pin history alone.

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int NPINS = 16,
  parameter int AW = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [NPINS-1:0] wdata,
  output logic [NPINS-1:0] rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             irq
);
  localparam logic [AW-1:0] A_DIR  = 'h00;
  localparam logic [AW-1:0] A_MODE = 'h04;
  localparam logic [AW-1:0] A_POL  = 'h08;
  localparam logic [AW-1:0] A_RISE = 'h0C;
  localparam logic [AW-1:0] A_FALL = 'h10;
  localparam logic [AW-1:0] A_DIN  = 'h14;
  localparam logic [AW-1:0] A_SET  = 'h18;
  localparam logic [AW-1:0] A_CLR  = 'h1C;
  localparam logic [AW-1:0] A_OUT  = 'h20;
  localparam logic [AW-1:0] A_MASK = 'h28;
  localparam logic [AW-1:0] A_IEN  = 'h2C;
  localparam logic [AW-1:0] A_STAT = 'h30;
  localparam logic [AW-1:0] A_ACK  = 'h34;

  logic [NPINS-1:0] dir_q, mode_q, pol_q, rise_q, fall_q, out_q, mask_q, ien_q;
  logic [NPINS-1:0] s1_q, s2_q, s3_q, pend_q;

  wire [NPINS-1:0] ack_vec  = (wr_en && addr == A_ACK) ? wdata : '0;
  wire [NPINS-1:0] edge_hit = ~mode_q & ((rise_q & s2_q & ~s3_q) | (fall_q & ~s2_q & s3_q));
  wire [NPINS-1:0] lvl_hit  = mode_q & ~(s2_q ^ pol_q);
  wire [NPINS-1:0] raw_st   = lvl_hit | (~mode_q & pend_q);
  wire [NPINS-1:0] st_gated = raw_st & ~mask_q & ien_q;

  assign pin_out = out_q;
  assign pin_oe  = dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0; mode_q <= '0; pol_q <= '0; rise_q <= '0; fall_q <= '0;
      out_q <= '0; mask_q <= '1; ien_q <= '0;
    end else if (wr_en) begin
      case (addr)
        A_DIR:  dir_q  <= wdata;
        A_MODE: mode_q <= wdata;
        A_POL:  pol_q  <= wdata;
        A_RISE: rise_q <= wdata;
        A_FALL: fall_q <= wdata;
        A_SET:  out_q  <= out_q | wdata;
        A_CLR:  out_q  <= out_q & ~wdata;
        A_OUT:  out_q  <= wdata;
        A_MASK: mask_q <= wdata;
        A_IEN:  ien_q  <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0; s2_q <= '0; s3_q <= '0; pend_q <= '0; irq <= 1'b0;
    end else begin
      s1_q   <= pin_in;
      s2_q   <= s1_q;
      s3_q   <= s2_q;
      pend_q <= (pend_q & ~ack_vec) | edge_hit;
      irq    <= |st_gated;
    end
  end

  always_comb begin
    case (addr)
      A_DIR:  rdata = dir_q;
      A_MODE: rdata = mode_q;
      A_POL:  rdata = pol_q;
      A_RISE: rdata = rise_q;
      A_FALL: rdata = fall_q;
      A_DIN:  rdata = s2_q;
      A_OUT:  rdata = out_q;
      A_MASK: rdata = mask_q;
      A_IEN:  rdata = ien_q;
      A_STAT: rdata = st_gated;
      default: rdata = '0;
    endcase
  end

  assert_irq_lag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq == $past(|st_gated));
  assert_edge_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_hit) |=> ((pend_q & $past(edge_hit)) == $past(edge_hit)));
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pend_q) & ~$past(ack_vec) & ~pend_q) == '0));
  assert_w1s_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_SET) |=> ((out_q & $past(wdata)) == $past(wdata)));
  assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CLR) |=> ((out_q & $past(wdata)) == '0));
endmodule

// File: tb/gpio_irq_ctrl_test.sv
module gpio_irq_ctrl_test;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [5:0] addr = 0;
  logic [15:0] wdata = 0, pin_in = 0;
  logic [15:0] rdata, pin_out, pin_oe;
  logic irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  gpio_irq_ctrl uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

  always #5 clk = ~clk;

  task automatic chk(input logic [15:0] got, input logic [15:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rdchk(input logic [5:0] a, input logic [15:0] exp, input string tag);
    addr = a; #1;
    chk(rdata, exp, tag);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    cyc(2); rst_n = 1; cyc(1);
    // R1 reset state, R10 holes
    rdchk(6'h00, 16'h0, "R1 dir");   rdchk(6'h04, 16'h0, "R1 mode");
    rdchk(6'h08, 16'h0, "R1 pol");   rdchk(6'h0C, 16'h0, "R1 rise");
    rdchk(6'h10, 16'h0, "R1 fall");  rdchk(6'h20, 16'h0, "R1 out");
    rdchk(6'h28, 16'hFFFF, "R1 mask"); rdchk(6'h2C, 16'h0, "R1 ien");
    rdchk(6'h30, 16'h0, "R1 status");
    chk({15'd0, irq}, 16'h0, "R1 irq"); chk(pin_oe, 16'h0, "R1 oe");
    rdchk(6'h24, 16'h0, "R10 hole 24"); rdchk(6'h38, 16'h0, "R10 hole 38");
    rdchk(6'h3C, 16'h0, "R10 hole 3C");

    // R2 direction
    for (int k = 0; k < 16; k++) begin
      wr(6'h00, 16'(1 << k) ^ 16'hA5C3);
      chk(pin_oe, 16'(1 << k) ^ 16'hA5C3, "R2 oe");
    end

    // R3 set / clear / load
    wr(6'h18, 16'h00F0); wr(6'h18, 16'h0F00);
    rdchk(6'h20, 16'h0FF0, "R3 set");
    wr(6'h1C, 16'h0030); rdchk(6'h20, 16'h0FC0, "R3 clear");
    chk(pin_out, 16'h0FC0, "R3 pin_out");
    for (int k = 0; k < 16; k++) begin
      logic [15:0] e;
      wr(6'h20, 16'h0);
      wr(6'h18, 16'(1 << k)); e = 16'(1 << k);
      chk(pin_out, e, "R3 set bit");
      wr(6'h18, 16'h8001); e |= 16'h8001;
      wr(6'h1C, 16'(1 << k)); e &= ~16'(1 << k);
      chk(pin_out, e, "R3 clear bit");
    end
    wr(6'h20, 16'h1234); rdchk(6'h20, 16'h1234, "R3 load");

    // R4 synchronised input
    for (int k = 0; k < 8; k++) begin
      logic [15:0] old, nw;
      old = pin_in; nw = 16'(k * 16'h3A5B + 16'h0101);
      pin_in = nw; addr = 6'h14;
      @(negedge clk); #1 chk(rdata, old, "R4 one edge");
      @(negedge clk); #1 chk(rdata, nw, "R4 two edges");
    end
    pin_in = 0; cyc(4);

    // R5 edge modes, R9 irq
    wr(6'h28, 16'h0); wr(6'h2C, 16'hFFFF); wr(6'h04, 16'h0);
    for (int m = 0; m < 3; m++) begin
      logic rs, fl;
      rs = (m != 1); fl = (m != 0);
      wr(6'h0C, rs ? 16'hFFFF : 16'h0); wr(6'h10, fl ? 16'hFFFF : 16'h0);
      wr(6'h34, 16'hFFFF); cyc(2);
      for (int i = 0; i < 16; i++) begin
        pin_in = 16'(1 << i); cyc(5);
        rdchk(6'h30, rs ? 16'(1 << i) : 16'h0, "R5 rise");
        chk({15'd0, irq}, {15'd0, rs}, "R9 irq rise");
        wr(6'h34, 16'hFFFF); cyc(2);
        rdchk(6'h30, 16'h0, "R8 cleared");
        chk({15'd0, irq}, 16'h0, "R9 irq low");
        pin_in = 0; cyc(5);
        rdchk(6'h30, fl ? 16'(1 << i) : 16'h0, "R5 fall");
        chk({15'd0, irq}, {15'd0, fl}, "R9 irq fall");
        wr(6'h34, 16'hFFFF); cyc(2);
      end
    end

    // R6 level modes
    wr(6'h0C, 16'h0); wr(6'h10, 16'h0); wr(6'h04, 16'hFFFF); wr(6'h08, 16'hFFFF);
    cyc(2); rdchk(6'h30, 16'h0, "R6 high idle");
    for (int i = 0; i < 16; i++) begin
      pin_in = 16'(1 << i); cyc(4);
      rdchk(6'h30, 16'(1 << i), "R6 high active");
      wr(6'h34, 16'(1 << i)); cyc(2);
      rdchk(6'h30, 16'(1 << i), "R6 clear ignored");
      chk({15'd0, irq}, 16'h1, "R6 irq held");
      pin_in = 0; cyc(4);
      rdchk(6'h30, 16'h0, "R6 high released");
    end
    wr(6'h08, 16'h0); cyc(1);
    rdchk(6'h30, 16'hFFFF, "R6 low active");
    pin_in = 16'hFFFF; cyc(4);
    rdchk(6'h30, 16'h0, "R6 low released");

    // R7 gating, R8 partial clear
    wr(6'h04, 16'h0); wr(6'h0C, 16'hFFFF);
    pin_in = 16'h0; cyc(4); wr(6'h34, 16'hFFFF);
    pin_in = 16'hFFFF; cyc(5);
    for (int k = 0; k < 12; k++) begin
      logic [15:0] mk, en;
      mk = 16'(k * 16'h1357); en = 16'(k * 16'h2468 + 16'h00FF);
      wr(6'h28, mk); wr(6'h2C, en); cyc(1);
      rdchk(6'h30, ~mk & en, "R7 gate");
      chk({15'd0, irq}, {15'd0, |(~mk & en)}, "R9 gated irq");
    end
    wr(6'h28, 16'h0); wr(6'h2C, 16'hFFFF);
    wr(6'h34, 16'h00FF); rdchk(6'h30, 16'hFF00, "R8 partial");
    wr(6'h34, 16'h0000); rdchk(6'h30, 16'hFF00, "R8 zero write");

    finish_up();
  end
endmodule